// File: doc/BRIEF.md
# TCP Transmit Segment Scheduler

This block decides, cycle by cycle, whether a single-stream TCP sender should emit its next data segment and how many bytes that segment carries. Payload is held upstream in a buffer of 64-bit words, so every length the block produces is a whole number of 8-byte words. Each cycle it looks at the unsent byte count, the bytes already in flight, the peer's advertised window with its negotiated scale shift, and the configured MTU. From these it derives the maximum segment size, the usable window and a send decision.

When a segment is granted, a one-cycle strobe carries the byte offset of the segment (its distance from the oldest unacknowledged byte) and its length to the packet builder. The scheduler merges small writes while data is still outstanding. It also refuses windows too small to be worth a segment. When the usable window is closed while data waits, it raises a flag so that the timer unit can start window probes. Upstream counters are expected to reflect a granted segment before the builder signals ready again.

Top module: `tcp_seg_sched`

## Requirements
- R1: While reset is asserted, and on the first edge after it, seg_valid and persist_req are 0 and seg_offset and seg_len are 0. Reset also clears the record of the largest window seen.
- R2: The segment size limit is min(mtu_bytes, 9000) minus 40, rounded down to a multiple of 8 bytes. An MTU of 40 bytes or less gives a limit of zero, and then nothing is sent.
- R3: The peer window in bytes is adv_wnd shifted left by wnd_shift, so it may exceed 65535. The usable window is that value minus inflight_bytes, or zero when in-flight data exceeds it.
- R4: A granted segment's length is the smallest of the segment size limit, the usable window and unsent_bytes, rounded down to a multiple of 8 bytes. It is never zero. Fewer than 8 unsent bytes means no segment.
- R5: While inflight_bytes is non-zero, no segment is sent unless unsent_bytes is at least one full segment size limit. With nothing in flight, a short segment may go out.
- R6: No segment is sent when the usable window is non-zero but below the lesser of the segment size limit and half of the largest peer window (in words) presented since reset, the current cycle included.
- R7: persist_req is 1 exactly when at least 8 bytes are unsent, the segment size limit is non-zero and the usable window is zero. A segment is never granted in that cycle.
- R8: With tx_ready low, no segment is granted. When no segment is granted, seg_offset and seg_len read 0.
- R9: Outputs are registered: a decision on the inputs sampled at one rising edge appears after that edge. A granted segment's seg_offset equals the inflight_bytes value sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unsent_bytes | input | 32 | Bytes queued but not yet sent |
| inflight_bytes | input | 32 | Bytes sent and not yet acknowledged |
| adv_wnd | input | 16 | Peer's advertised window field |
| wnd_shift | input | 4 | Negotiated window scale shift |
| mtu_bytes | input | 14 | Configured MTU in bytes |
| tx_ready | input | 1 | Packet builder can accept a segment |
| seg_valid | output | 1 | One-cycle strobe: segment granted |
| seg_offset | output | 32 | Segment start, in bytes from the oldest unacknowledged byte |
| seg_len | output | 32 | Segment length in bytes, multiple of 8 |
| persist_req | output | 1 | Window closed while data waits |

## Verification
Every cycle, the assertions tie each grant to the inputs sampled one edge earlier. A grant never exceeds the unsent data, the scaled usable window or the size limit from the clamped MTU. Grants never happen with tx_ready low or in a zero-window cycle, and no short segment leaves while data is in flight. The exact segment lengths, and the refusal of small windows, depend on the largest window seen since reset, so only the bench's vector table and directed sequences can show them. The same holds for the MTU clamp and the clearing of that history by reset.

// File: rtl/tcp_sched_pkg.sv
package tcp_sched_pkg;

  // Reason behind each cycle's scheduling decision
  typedef enum logic [2:0] {
    WHY_SEND     = 3'd0,
    WHY_NODATA   = 3'd1,
    WHY_NOMSS    = 3'd2,
    WHY_ZERO_WIN = 3'd3,
    WHY_SILLY    = 3'd4,
    WHY_NAGLE    = 3'd5,
    WHY_BLOCKED  = 3'd6
  } sched_why_e;

  localparam int unsigned WORD_BYTES_LOG2 = 3;

endpackage

// File: rtl/tcp_mss_calc.sv
module tcp_mss_calc #(
  parameter int unsigned MTU_W     = 14,
  parameter int unsigned MAX_MTU   = 9000,
  parameter int unsigned HDR_BYTES = 40,
  localparam int unsigned MSSW_W   = MTU_W - 3
) (
  input  logic [MTU_W-1:0]  mtu_bytes,
  output logic [MSSW_W-1:0] mss_words
);

  localparam logic [MTU_W-1:0] MTU_CAP = MTU_W'(MAX_MTU);
  localparam logic [MTU_W-1:0] HDR_LEN = MTU_W'(HDR_BYTES);

  logic [MTU_W-1:0] mtu_clamped;
  logic [MTU_W-1:0] payload_bytes;

  always_comb begin
    mtu_clamped   = (mtu_bytes > MTU_CAP) ? MTU_CAP : mtu_bytes;
    payload_bytes = (mtu_clamped > HDR_LEN) ? (mtu_clamped - HDR_LEN) : '0;
    mss_words     = payload_bytes[MTU_W-1:3];
  end

endmodule

// File: rtl/tcp_wnd_track.sv
module tcp_wnd_track #(
  parameter int unsigned BYTE_W  = 32,
  parameter int unsigned ADV_W   = 16,
  parameter int unsigned SHIFT_W = 4,
  localparam int unsigned WORD_W = BYTE_W - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADV_W-1:0]   adv_wnd,
  input  logic [SHIFT_W-1:0] wnd_shift,
  input  logic [BYTE_W-1:0]  inflight_bytes,
  output logic [WORD_W-1:0]  usable_words,
  output logic [WORD_W-1:0]  max_seen_words
);

  logic [BYTE_W-1:0] scaled_bytes;
  logic [BYTE_W-1:0] usable_bytes;
  logic [WORD_W-1:0] cur_words;
  logic [WORD_W-1:0] max_q;
  logic [WORD_W-1:0] max_d;
  logic              max_en;

  always_comb begin
    scaled_bytes   = BYTE_W'(adv_wnd) << wnd_shift;
    usable_bytes   = (scaled_bytes > inflight_bytes) ? (scaled_bytes - inflight_bytes) : '0;
    usable_words   = usable_bytes[BYTE_W-1:3];
    cur_words      = scaled_bytes[BYTE_W-1:3];
    max_en         = cur_words > max_q;
    max_d          = cur_words;
    max_seen_words = max_en ? cur_words : max_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
    end else if (max_en) begin
      max_q <= max_d;
    end
  end

endmodule

// File: rtl/tcp_seg_decide.sv
module tcp_seg_decide
  import tcp_sched_pkg::*;
#(
  parameter int unsigned BYTE_W = 32,
  parameter int unsigned MTU_W  = 14,
  localparam int unsigned WORD_W = BYTE_W - 3,
  localparam int unsigned MSSW_W = MTU_W - 3
) (
  input  logic [BYTE_W-1:0] unsent_bytes,
  input  logic [BYTE_W-1:0] inflight_bytes,
  input  logic [MSSW_W-1:0] mss_words,
  input  logic [WORD_W-1:0] usable_words,
  input  logic [WORD_W-1:0] max_seen_words,
  input  logic              tx_ready,
  output sched_why_e        why,
  output logic [WORD_W-1:0] len_words
);

  logic [WORD_W-1:0] unsent_words;
  logic [WORD_W-1:0] mss_ext;
  logic [WORD_W-1:0] half_max;
  logic [WORD_W-1:0] silly_thr;
  logic [WORD_W-1:0] lim_a;
  logic              short_seg;

  always_comb begin
    unsent_words = unsent_bytes[BYTE_W-1:3];
    mss_ext      = WORD_W'(mss_words);
    half_max     = max_seen_words >> 1;
    silly_thr    = (mss_ext < half_max) ? mss_ext : half_max;
    lim_a        = (mss_ext < usable_words) ? mss_ext : usable_words;
    len_words    = (lim_a < unsent_words) ? lim_a : unsent_words;
    short_seg    = unsent_words < mss_ext;

    if (unsent_words == '0) begin
      why = WHY_NODATA;
    end else if (mss_ext == '0) begin
      why = WHY_NOMSS;
    end else if (usable_words == '0) begin
      why = WHY_ZERO_WIN;
    end else if (usable_words < silly_thr) begin
      why = WHY_SILLY;
    end else if (short_seg && (inflight_bytes != '0)) begin
      why = WHY_NAGLE;
    end else if (!tx_ready) begin
      why = WHY_BLOCKED;
    end else begin
      why = WHY_SEND;
    end
  end

endmodule

// File: rtl/tcp_seg_sched.sv
module tcp_seg_sched
  import tcp_sched_pkg::*;
#(
  parameter int unsigned BYTE_W    = 32,
  parameter int unsigned ADV_W     = 16,
  parameter int unsigned SHIFT_W   = 4,
  parameter int unsigned MTU_W     = 14,
  parameter int unsigned MAX_MTU   = 9000,
  parameter int unsigned HDR_BYTES = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  unsent_bytes,
  input  logic [BYTE_W-1:0]  inflight_bytes,
  input  logic [ADV_W-1:0]   adv_wnd,
  input  logic [SHIFT_W-1:0] wnd_shift,
  input  logic [MTU_W-1:0]   mtu_bytes,
  input  logic               tx_ready,
  output logic               seg_valid,
  output logic [BYTE_W-1:0]  seg_offset,
  output logic [BYTE_W-1:0]  seg_len,
  output logic               persist_req
);

  localparam int unsigned WORD_W = BYTE_W - 3;
  localparam int unsigned MSSW_W = MTU_W - 3;

  logic [MSSW_W-1:0] mss_words;
  logic [WORD_W-1:0] usable_words;
  logic [WORD_W-1:0] max_seen_words;
  logic [WORD_W-1:0] len_words;
  sched_why_e        why;

  logic              valid_d;
  logic [BYTE_W-1:0] offset_d;
  logic [BYTE_W-1:0] len_d;
  logic              persist_d;

  tcp_mss_calc #(
    .MTU_W    (MTU_W),
    .MAX_MTU  (MAX_MTU),
    .HDR_BYTES(HDR_BYTES)
  ) mss_i (
    .mtu_bytes(mtu_bytes),
    .mss_words(mss_words)
  );

  tcp_wnd_track #(
    .BYTE_W (BYTE_W),
    .ADV_W  (ADV_W),
    .SHIFT_W(SHIFT_W)
  ) wnd_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv_wnd       (adv_wnd),
    .wnd_shift     (wnd_shift),
    .inflight_bytes(inflight_bytes),
    .usable_words  (usable_words),
    .max_seen_words(max_seen_words)
  );

  tcp_seg_decide #(
    .BYTE_W(BYTE_W),
    .MTU_W (MTU_W)
  ) dec_i (
    .unsent_bytes  (unsent_bytes),
    .inflight_bytes(inflight_bytes),
    .mss_words     (mss_words),
    .usable_words  (usable_words),
    .max_seen_words(max_seen_words),
    .tx_ready      (tx_ready),
    .why           (why),
    .len_words     (len_words)
  );

  // Next-state: outputs are zero unless a segment is granted
  always_comb begin
    valid_d   = (why == WHY_SEND);
    persist_d = (why == WHY_ZERO_WIN);
    offset_d  = valid_d ? inflight_bytes : '0;
    len_d     = valid_d ? {len_words, 3'b000} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_valid   <= 1'b0;
      seg_offset  <= '0;
      seg_len     <= '0;
      persist_req <= 1'b0;
    end else begin
      seg_valid   <= valid_d;
      seg_offset  <= offset_d;
      seg_len     <= len_d;
      persist_req <= persist_d;
    end
  end

endmodule

// File: rtl/tcp_seg_sched_chk.sv
module tcp_seg_sched_chk #(
  parameter int unsigned BYTE_W    = 32,
  parameter int unsigned ADV_W     = 16,
  parameter int unsigned SHIFT_W   = 4,
  parameter int unsigned MTU_W     = 14,
  parameter int unsigned MAX_MTU   = 9000,
  parameter int unsigned HDR_BYTES = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic [BYTE_W-1:0]  unsent_bytes,
  input logic [BYTE_W-1:0]  inflight_bytes,
  input logic [ADV_W-1:0]   adv_wnd,
  input logic [SHIFT_W-1:0] wnd_shift,
  input logic [MTU_W-1:0]   mtu_bytes,
  input logic               tx_ready,
  input logic               seg_valid,
  input logic [BYTE_W-1:0]  seg_offset,
  input logic [BYTE_W-1:0]  seg_len,
  input logic               persist_req
);

  logic [63:0] win_bytes;
  logic [63:0] cap_mtu;
  logic [63:0] size_lim;

  always_comb begin
    win_bytes = 64'(adv_wnd) << wnd_shift;
    cap_mtu   = (64'(mtu_bytes) > 64'(MAX_MTU)) ? 64'(MAX_MTU) : 64'(mtu_bytes);
    size_lim  = (cap_mtu > 64'(HDR_BYTES)) ? ((cap_mtu - 64'(HDR_BYTES)) & ~64'd7) : 64'd0;
  end

  // R4
  len_within_unsent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len <= $past(unsent_bytes)) && (seg_len != '0));

  // R3
  len_within_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (64'(seg_len) + 64'($past(inflight_bytes)) <= $past(win_bytes)));

  // R2
  len_within_mss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (64'(seg_len) <= $past(size_lim)));

  // R5
  nagle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && ($past(inflight_bytes) != '0)) |-> (64'($past(unsent_bytes)) >= $past(size_lim)));

  // R8
  no_grant_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_ready) |-> !seg_valid);

  // R7
  persist_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    persist_req |-> !seg_valid);

  // R9
  offset_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_offset == $past(inflight_bytes)));

endmodule

bind tcp_seg_sched tcp_seg_sched_chk #(
  .BYTE_W   (BYTE_W),
  .ADV_W    (ADV_W),
  .SHIFT_W  (SHIFT_W),
  .MTU_W    (MTU_W),
  .MAX_MTU  (MAX_MTU),
  .HDR_BYTES(HDR_BYTES)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .unsent_bytes  (unsent_bytes),
  .inflight_bytes(inflight_bytes),
  .adv_wnd       (adv_wnd),
  .wnd_shift     (wnd_shift),
  .mtu_bytes     (mtu_bytes),
  .tx_ready      (tx_ready),
  .seg_valid     (seg_valid),
  .seg_offset    (seg_offset),
  .seg_len       (seg_len),
  .persist_req   (persist_req)
);

// File: tb/tcp_seg_sched_tb_top.sv
module tcp_seg_sched_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] unsent_bytes;
  logic [31:0] inflight_bytes;
  logic [15:0] adv_wnd;
  logic [3:0]  wnd_shift;
  logic [13:0] mtu_bytes;
  logic        tx_ready;
  logic        seg_valid;
  logic [31:0] seg_offset;
  logic [31:0] seg_len;
  logic        persist_req;

  int n_tests;
  int n_fail;
  int cycles;
  bit done;

  tcp_seg_sched dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .unsent_bytes  (unsent_bytes),
    .inflight_bytes(inflight_bytes),
    .adv_wnd       (adv_wnd),
    .wnd_shift     (wnd_shift),
    .mtu_bytes     (mtu_bytes),
    .tx_ready      (tx_ready),
    .seg_valid     (seg_valid),
    .seg_offset    (seg_offset),
    .seg_len       (seg_len),
    .persist_req   (persist_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] unsent;
    logic [31:0] inflight;
    logic [15:0] adv;
    logic [3:0]  shift;
    logic [13:0] mtu;
    logic        ready;
    logic        exp_valid;
    logic [31:0] exp_len;
    logic        exp_persist;
  } vec_t;

  localparam int NVEC = 14;
  // Each vector is applied right after a reset, so the largest window seen is the current one.
  localparam vec_t VECS [NVEC] = '{
    '{32'd4000,   32'd0,     16'd65535, 4'd0, 14'd1500,  1'b1, 1'b1, 32'd1456, 1'b0}, // R4 MSS-bound
    '{32'd20000,  32'd0,     16'd65535, 4'd0, 14'd9000,  1'b1, 1'b1, 32'd8960, 1'b0}, // R2 jumbo
    '{32'd100000, 32'd70000, 16'd1000,  4'd7, 14'd9000,  1'b1, 1'b1, 32'd8960, 1'b0}, // R3 scaled > 64K
    '{32'd100,    32'd800,   16'd65535, 4'd0, 14'd1500,  1'b1, 1'b0, 32'd0,    1'b0}, // R5 Nagle hold
    '{32'd100,    32'd0,     16'd65535, 4'd0, 14'd1500,  1'b1, 1'b1, 32'd96,   1'b0}, // R5 idle short
    '{32'd103,    32'd0,     16'd65535, 4'd0, 14'd1500,  1'b1, 1'b1, 32'd96,   1'b0}, // R4 round down
    '{32'd3000,   32'd0,     16'd0,     4'd0, 14'd1500,  1'b1, 1'b0, 32'd0,    1'b1}, // R7 zero window
    '{32'd3000,   32'd2000,  16'd1000,  4'd0, 14'd1500,  1'b1, 1'b0, 32'd0,    1'b1}, // R3 shrunk window
    '{32'd5000,   32'd3200,  16'd4000,  4'd0, 14'd1500,  1'b1, 1'b0, 32'd0,    1'b0}, // R6 silly window
    '{32'd5000,   32'd2544,  16'd4000,  4'd0, 14'd1500,  1'b1, 1'b1, 32'd1456, 1'b0}, // R6 at threshold
    '{32'd4000,   32'd0,     16'd65535, 4'd0, 14'd1500,  1'b0, 1'b0, 32'd0,    1'b0}, // R8 not ready
    '{32'd4000,   32'd0,     16'd65535, 4'd0, 14'd40,    1'b1, 1'b0, 32'd0,    1'b0}, // R2 tiny MTU
    '{32'd20000,  32'd0,     16'd65535, 4'd0, 14'd12000, 1'b1, 1'b1, 32'd8960, 1'b0}, // R2 clamp
    '{32'd7,      32'd0,     16'd0,     4'd0, 14'd1500,  1'b1, 1'b0, 32'd0,    1'b0}  // R4/R7 no full word
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic [31:0] un, input logic [31:0] inf, input logic [15:0] adv,
                       input logic [3:0] sh, input logic [13:0] mtu, input logic rdy);
    unsent_bytes   = un;
    inflight_bytes = inf;
    adv_wnd        = adv;
    wnd_shift      = sh;
    mtu_bytes      = mtu;
    tx_ready       = rdy;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    cycles  = 0;
    done    = 1'b0;
    drive(32'd4000, 32'd0, 16'd65535, 4'd0, 14'd1500, 1'b1);
    rst_n = 1'b0;
    #12;
    // R1: outputs held at zero during reset even with a sendable input
    check("R1", "valid in reset", 32'(seg_valid), 32'd0);
    check("R1", "len in reset", seg_len, 32'd0);
    @(posedge clk);
    #1;
    check("R1", "persist in reset", 32'(persist_req), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(32'd0, 32'd0, 16'd0, 4'd0, 14'd1500, 1'b0);
      do_reset();
      drive(VECS[i].unsent, VECS[i].inflight, VECS[i].adv, VECS[i].shift, VECS[i].mtu, VECS[i].ready);
      @(negedge clk);
      check("R4", $sformatf("vec %0d valid", i), 32'(seg_valid), 32'(VECS[i].exp_valid));
      check("R4", $sformatf("vec %0d len", i), seg_len, VECS[i].exp_len);
      check("R9", $sformatf("vec %0d offset", i), seg_offset,
            VECS[i].exp_valid ? VECS[i].inflight : 32'd0);
      check("R7", $sformatf("vec %0d persist", i), 32'(persist_req), 32'(VECS[i].exp_persist));
    end

    // R6: history of a large window makes a later small window too small to use
    drive(32'd0, 32'd0, 16'd0, 4'd0, 14'd9000, 1'b1);
    do_reset();
    drive(32'd0, 32'd0, 16'd60000, 4'd0, 14'd9000, 1'b1);
    @(negedge clk);
    check("R4", "no data no send", 32'(seg_valid), 32'd0);
    drive(32'd5000, 32'd0, 16'd2000, 4'd0, 14'd9000, 1'b1);
    @(negedge clk);
    check("R6", "small window after large", 32'(seg_valid), 32'd0);
    check("R6", "small window len", seg_len, 32'd0);

    // R1: reset forgets the history, so the same window is now usable
    do_reset();
    drive(32'd5000, 32'd0, 16'd2000, 4'd0, 14'd9000, 1'b1);
    @(negedge clk);
    check("R1", "history cleared valid", 32'(seg_valid), 32'd1);
    check("R1", "history cleared len", seg_len, 32'd2000);

    // R9: strobe follows input by one edge and drops when input changes
    drive(32'd5000, 32'd0, 16'd2000, 4'd0, 14'd9000, 1'b0);
    @(negedge clk);
    check("R9", "strobe drops next cycle", 32'(seg_valid), 32'd0);
    check("R8", "len zero without grant", seg_len, 32'd0);

    // R5: exactly one MSS unsent with data in flight is allowed
    do_reset();
    drive(32'd1456, 32'd8, 16'd65535, 4'd0, 14'd1500, 1'b1);
    @(negedge clk);
    check("R5", "full MSS with inflight", seg_len, 32'd1456);
    check("R9", "offset equals inflight", seg_offset, 32'd8);

    finish_run();
  end

endmodule